// File: doc/BRIEF.md
# Single-Bit Test-and-Branch / Set-and-Clear Execute Unit

This block is the execute stage for the direct-page single-bit instructions of an 8-bit microcontroller core. It handles two instruction groups. The first tests one bit of a memory byte and branches on it. The second sets or clears one bit of a memory byte and returns the new byte for write-back. Instruction fetch, addressing and memory timing belong to the surrounding core.

The core presents one instruction per `start` pulse. With it, the core supplies the opcode, the operand byte already read from memory, the signed displacement byte, the current program counter and the current carry flag. One clock later the unit raises `done` for a single cycle and presents the results:

- the next program counter,
- the new carry flag,
- the modified byte, with a one-cycle write strobe,
- the instruction's cycle count,
- an illegal-opcode flag.

The bit index is always opcode bits [3:1]. Opcode bit 0 selects the polarity of the instruction.

Top module: `bitop_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after reset until the first `start`, the outputs `done`, `wr_en`, `illegal`, `carry_out`, `next_pc`, `wr_data` and `cycles` are all zero.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is sampled high, and is low otherwise.
- R3: For opcodes 0x00–0x0F, the tested bit is bit n of `operand`, where n = opcode[3:1]. An even opcode branches when that bit is 1. An odd opcode branches when that bit is 0. A taken branch gives `next_pc` = `pc_in` + 3 + `disp`, with `disp` read as two's complement. A branch that is not taken gives `pc_in` + 3.
- R4: For opcodes 0x00–0x0F, `carry_out` equals the tested bit, whatever the polarity.
- R5: For opcodes 0x10–0x1F, `wr_data` is `operand` with bit n (n = opcode[3:1]) forced to 1 when the opcode is even and forced to 0 when it is odd. All other bits are unchanged.
- R6: For opcodes 0x10–0x1F, `next_pc` = `pc_in` + 2 and `carry_out` = `carry_in`.
- R7: `wr_en` is high for exactly the single `done` cycle of an opcode in 0x10–0x1F. It is never high for any other opcode.
- R8: `cycles` reports 5 for opcodes 0x00–0x0F, 4 for opcodes 0x10–0x1F, and 0 for illegal opcodes.
- R9: For opcodes 0x20–0xFF, `illegal` is high with `done`. In that case `next_pc` = `pc_in`, `carry_out` = `carry_in`, `wr_data` = `operand`, and `wr_en` stays low.
- R10: `next_pc` arithmetic wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction valid; inputs are sampled in this cycle |
| opcode | input | 8 | Instruction opcode |
| operand | input | 8 | Memory byte at the direct address |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Program counter of the instruction |
| carry_in | input | 1 | Current carry flag |
| done | output | 1 | Result valid, one cycle |
| next_pc | output | 16 | Program counter after the instruction |
| carry_out | output | 1 | Carry flag after the instruction |
| wr_data | output | 8 | Byte to write back to memory |
| wr_en | output | 1 | Write strobe for `wr_data`, one cycle |
| cycles | output | 3 | Instruction cycle count |
| illegal | output | 1 | Opcode outside 0x00–0x1F |

## Verification
The hardest case to reach is a polarity or index error that shows up only for one opcode paired with one operand bit value. A test that uses a few typical bytes can miss it. The stimulus therefore crosses all 32 legal opcodes with all 256 operand bytes, so every bit position is exercised in both states under both polarities. The carry input and the displacement vary with the loop indices, so taken and untaken branches occur with both forward and backward offsets. Program counters near 0x0000 and 0xFFFF are driven deliberately, to reach the wrap in both directions.

// File: rtl/bitop_pkg.sv
// Package: shared types and constants for the single-bit execute unit.
// The opcode layout is fixed: bits [7:5] select the legal range,
// bit 4 separates branch from modify, bits [3:1] give the bit index,
// and bit 0 gives the polarity.
package bitop_pkg;

    localparam int OPC_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(BYTE_W);

    // Instruction lengths in bytes (PC advance).
    localparam int BRANCH_LEN = 3;
    localparam int MODIFY_LEN = 2;

    typedef enum logic [1:0] {
        KIND_BRANCH  = 2'd0,
        KIND_MODIFY  = 2'd1,
        KIND_ILLEGAL = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [IDX_W-1:0]   bit_idx;
        logic               invert;
    } op_dec_t;

endpackage

// File: rtl/bitop_decode.sv
// Module: bitop_decode
// Purpose: classifies an opcode into branch, modify or illegal, and
// extracts the bit index and the polarity.
// Assumes: an 8-bit opcode; only 0x00-0x1F are legal.
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_dec_t          dec
);

    // Split the opcode into its fields and pick the instruction class.
    always_comb begin
        dec.bit_idx = opcode[IDX_W:1];
        dec.invert  = opcode[0];
        if (opcode[7:5] != 3'b000) begin
            dec.kind = KIND_ILLEGAL;
        end else if (opcode[4]) begin
            dec.kind = KIND_MODIFY;
        end else begin
            dec.kind = KIND_BRANCH;
        end
    end

endmodule

// File: rtl/bitop_branch.sv
// Module: bitop_branch
// Purpose: selects the tested bit, resolves the branch condition and
// forms both candidate program counters.
// Assumes: PC_W > 8; the displacement is two's complement; the sums
// wrap modulo 2^PC_W.
module bitop_branch
    import bitop_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] disp,
    input  logic [BYTE_W-1:0] operand,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              invert,
    output logic              tested_bit,
    output logic [PC_W-1:0]   pc_branch,
    output logic [PC_W-1:0]   pc_modify
);

    localparam int EXT_W = PC_W - BYTE_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] pc_seq;
    logic            take;

    // Pick the addressed bit and apply the polarity.
    always_comb begin
        tested_bit = operand[bit_idx];
        take       = tested_bit ^ invert;
    end

    // Sign-extend the displacement to the PC width.
    always_comb begin
        disp_ext = {{EXT_W{disp[BYTE_W-1]}}, disp};
    end

    // Form the sequential and branch targets, wrapping naturally.
    always_comb begin
        pc_seq    = pc_in + PC_W'(BRANCH_LEN);
        pc_branch = take ? (pc_seq + disp_ext) : pc_seq;
        pc_modify = pc_in + PC_W'(MODIFY_LEN);
    end

endmodule

// File: rtl/bitop_modify.sv
// Module: bitop_modify
// Purpose: forces one bit of the operand byte to 1 (set) or to 0
// (clear) and passes the other bits through.
// Assumes: invert = 0 means set and invert = 1 means clear.
module bitop_modify
    import bitop_pkg::*;
(
    input  logic [BYTE_W-1:0] operand,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              invert,
    output logic [BYTE_W-1:0] result
);

    // One lane per bit: replace the addressed lane and keep the rest.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        always_comb begin
            if (bit_idx == IDX_W'(i)) begin
                result[i] = ~invert;
            end else begin
                result[i] = operand[i];
            end
        end
    end

endmodule

// File: rtl/bitop_exec.sv
// Module: bitop_exec (top)
// Purpose: execute stage for the single-bit test-and-branch and
// set/clear instructions. Inputs are sampled when start is high; the
// results are registered and presented with a one-cycle done pulse.
// Assumes: synchronous active-low reset; the surrounding core holds
// the results it needs after done, because they stay until the next
// start.
module bitop_exec
    import bitop_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int CYC_W      = 3,
    parameter int BR_CYCLES  = 5,
    parameter int MOD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        operand,
    input  logic [7:0]        disp,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              carry_in,
    output logic              done,
    output logic [PC_W-1:0]   next_pc,
    output logic              carry_out,
    output logic [7:0]        wr_data,
    output logic              wr_en,
    output logic [CYC_W-1:0]  cycles,
    output logic              illegal
);

    op_dec_t           dec;
    logic              tested_bit;
    logic [PC_W-1:0]   pc_branch;
    logic [PC_W-1:0]   pc_modify;
    logic [7:0]        mod_byte;

    logic [PC_W-1:0]   pc_d;
    logic              carry_d;
    logic [7:0]        data_d;
    logic              wr_d;
    logic [CYC_W-1:0]  cyc_d;
    logic              ill_d;

    bitop_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    bitop_branch #(.PC_W(PC_W)) u_branch (
        .pc_in      (pc_in),
        .disp       (disp),
        .operand    (operand),
        .bit_idx    (dec.bit_idx),
        .invert     (dec.invert),
        .tested_bit (tested_bit),
        .pc_branch  (pc_branch),
        .pc_modify  (pc_modify)
    );

    bitop_modify u_modify (
        .operand (operand),
        .bit_idx (dec.bit_idx),
        .invert  (dec.invert),
        .result  (mod_byte)
    );

    // Choose the result set that matches the decoded class.
    always_comb begin
        pc_d    = pc_in;
        carry_d = carry_in;
        data_d  = operand;
        wr_d    = 1'b0;
        cyc_d   = '0;
        ill_d   = 1'b0;
        unique case (dec.kind)
            KIND_BRANCH: begin
                pc_d    = pc_branch;
                carry_d = tested_bit;
                cyc_d   = CYC_W'(BR_CYCLES);
            end
            KIND_MODIFY: begin
                pc_d    = pc_modify;
                data_d  = mod_byte;
                wr_d    = 1'b1;
                cyc_d   = CYC_W'(MOD_CYCLES);
            end
            default: begin
                ill_d   = 1'b1;
            end
        endcase
    end

    // Generate the done and write pulses for one cycle per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            wr_en <= 1'b0;
        end else begin
            done  <= start;
            wr_en <= start & wr_d;
        end
    end

    // Capture the results when start is high; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc   <= '0;
            carry_out <= 1'b0;
            wr_data   <= '0;
            cycles    <= '0;
            illegal   <= 1'b0;
        end else if (start) begin
            next_pc   <= pc_d;
            carry_out <= carry_d;
            wr_data   <= data_d;
            cycles    <= cyc_d;
            illegal   <= ill_d;
        end
    end

endmodule

// File: rtl/bitop_exec_chk.sv
// Module: bitop_exec_chk
// Purpose: protocol and result checks on the ports of bitop_exec,
// attached through bind.
module bitop_exec_chk #(
    parameter int PC_W       = 16,
    parameter int CYC_W      = 3,
    parameter int BR_CYCLES  = 5,
    parameter int MOD_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [7:0]        opcode,
    input logic [PC_W-1:0]   pc_in,
    input logic              carry_in,
    input logic              done,
    input logic [PC_W-1:0]   next_pc,
    input logic              carry_out,
    input logic              wr_en,
    input logic [CYC_W-1:0]  cycles,
    input logic              illegal
);

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2
    done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R7
    write_needs_legal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && !illegal));

    // R7
    branch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode[7:4] == 4'h0) |=> !wr_en);

    // R8
    branch_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode[7:4] == 4'h0) |=> (cycles == CYC_W'(BR_CYCLES)));

    // R8
    modify_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode[7:4] == 4'h1) |=> (cycles == CYC_W'(MOD_CYCLES) && wr_en));

    // R6
    modify_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode[7:4] == 4'h1) |=>
            (next_pc == PC_W'($past(pc_in) + PC_W'(2)) && carry_out == $past(carry_in)));

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode[7:5] != 3'b000) |=>
            (illegal && !wr_en && next_pc == $past(pc_in) && carry_out == $past(carry_in)));

endmodule

bind bitop_exec bitop_exec_chk #(
    .PC_W       (PC_W),
    .CYC_W      (CYC_W),
    .BR_CYCLES  (BR_CYCLES),
    .MOD_CYCLES (MOD_CYCLES)
) u_bitop_exec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .pc_in     (pc_in),
    .carry_in  (carry_in),
    .done      (done),
    .next_pc   (next_pc),
    .carry_out (carry_out),
    .wr_en     (wr_en),
    .cycles    (cycles),
    .illegal   (illegal)
);

// File: tb/test_bitop_exec.sv
`timescale 1ns/1ps
module test_bitop_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  operand = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc_in = '0;
    logic        carry_in = 1'b0;
    logic        done;
    logic [15:0] next_pc;
    logic        carry_out;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic [2:0]  cycles;
    logic        illegal;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bitop_exec i_bitop_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .operand   (operand),
        .disp      (disp),
        .pc_in     (pc_in),
        .carry_in  (carry_in),
        .done      (done),
        .next_pc   (next_pc),
        .carry_out (carry_out),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .cycles    (cycles),
        .illegal   (illegal)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one instruction and compare every output with an arithmetic model.
    task automatic run_op(input int opc, input int opd, input int dsp, input int pc, input int cin);
        int exp_pc, exp_c, exp_data, exp_wr, exp_cyc, exp_ill, n, bitv, taken, sdisp;
        @(negedge clk);
        opcode = 8'(opc); operand = 8'(opd); disp = 8'(dsp);
        pc_in = 16'(pc); carry_in = cin[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n     = (opc / 2) % 8;
        bitv  = (opd / (1 << n)) % 2;
        sdisp = (dsp >= 128) ? dsp - 256 : dsp;
        if (opc < 16) begin
            taken    = (opc % 2 == 0) ? bitv : 1 - bitv;
            exp_pc   = (pc + 3 + (taken != 0 ? sdisp : 0) + 65536) % 65536;
            exp_c    = bitv; exp_data = opd; exp_wr = 0; exp_cyc = 5; exp_ill = 0;
            check("R3", "next_pc", int'(next_pc), exp_pc);
            check("R4", "carry", int'(carry_out), exp_c);
            check("R8", "cycles", int'(cycles), exp_cyc);
            check("R7", "wr_en", int'(wr_en), exp_wr);
        end else if (opc < 32) begin
            exp_data = (opc % 2 == 0) ? (opd | (1 << n)) : (opd & ~(1 << n) & 255);
            exp_pc   = (pc + 2) % 65536;
            check("R5", "wr_data", int'(wr_data), exp_data);
            check("R6", "next_pc", int'(next_pc), exp_pc);
            check("R6", "carry", int'(carry_out), cin);
            check("R8", "cycles", int'(cycles), 4);
            check("R7", "wr_en", int'(wr_en), 1);
        end else begin
            check("R9", "illegal", int'(illegal), 1);
            check("R9", "next_pc", int'(next_pc), pc);
            check("R9", "carry", int'(carry_out), cin);
            check("R9", "wr_data", int'(wr_data), opd);
            check("R9", "wr_en", int'(wr_en), 0);
            check("R8", "cycles", int'(cycles), 0);
        end
        if (opc < 32) check("R9", "illegal low", int'(illegal), 0);
        check("R2", "done", int'(done), 1);
        @(negedge clk);
        check("R2", "done pulse width", int'(done), 0);
        check("R7", "wr_en pulse width", int'(wr_en), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done", int'(done), 0);
        check("R1", "wr_en", int'(wr_en), 0);
        check("R1", "illegal", int'(illegal), 0);
        check("R1", "carry", int'(carry_out), 0);
        check("R1", "next_pc", int'(next_pc), 0);
        check("R1", "wr_data", int'(wr_data), 0);
        check("R1", "cycles", int'(cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after release", int'(done), 0);
        check("R1", "next_pc after release", int'(next_pc), 0);

        // Sweep all legal opcodes against every operand byte.
        for (int op = 0; op < 32; op++) begin
            for (int v = 0; v < 256; v++) begin
                run_op(op, v, (v * 37 + op) % 256, (v * 251 + op * 4099) % 65536, (v + op) % 2);
            end
        end

        // Illegal opcodes.
        for (int op = 32; op < 256; op += 7) begin
            run_op(op, op ^ 8'h5A, 8'h80, 16'h1234 + op, op % 2);
        end
        run_op(255, 8'hFF, 8'h7F, 16'hFFFF, 1);

        // R10: wrap checks in both directions.
        run_op(8'h00, 8'h01, 8'h05, 16'hFFFE, 0);
        check("R10", "forward wrap", int'(next_pc), 16'h0006);
        run_op(8'h03, 8'h00, 8'h80, 16'h0001, 1);
        check("R10", "backward wrap", int'(next_pc), 16'hFF84);
        run_op(8'h1E, 8'h00, 8'h00, 16'hFFFF, 0);
        check("R10", "modify wrap", int'(next_pc), 16'h0001);
        run_op(8'h0E, 8'h7F, 8'h10, 16'hFFFD, 0);
        check("R10", "not taken wrap", int'(next_pc), 16'h0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule